// File: doc/BRIEF.md
# Mode-Banked Register Index Mapper

This block turns a 6-bit register specifier taken from an instruction into a flat logical register number, using the current privilege mode to choose a bank. User mode sees all 64 general registers. Each of the three other modes sees only 32 registers, and those 32 are private to that mode. The whole logical space holds 160 entries. The output index is 9 bits wide so that it can address a downstream rename table of up to 512 entries. Registers carry no type tag, so integer and floating-point values map the same way.

The mapper also reports when a specifier is not allowed in the current mode. As an option it gives the index of the partner register used by 128-bit operations. The high half of a pair sits 32 above its low half, so user register 1 pairs with register 33. Requests enter and results leave on valid/ready handshakes. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the held result stays frozen and new requests are refused.

With `REG_OUT=1` (the default), the result is registered and the block adds one cycle of latency. It still accepts a request every cycle as long as the consumer is draining. With `REG_OUT=0`, the path is combinational, `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`.

Top module: `rmap_bank_mapper`

## Requirements
- R1: Mode code 0 is user mode. In user mode, any specifier s (0..63) yields logical index s, and the illegal flag stays low.
- R2: Mode codes 1, 2 and 3 are the other modes. In mode m, a specifier with bit 5 clear yields index 32 + 32*m + s[4:0]. The banks are therefore 64..95, 96..127 and 128..159, and the illegal flag stays low.
- R3: In modes 1 to 3, a specifier with bit 5 set raises the illegal flag and forces the logical index to 0.
- R4: Every legal logical index lies below 160.
- R5: With the pair output enabled, a user-mode specifier with bit 5 clear sets the pair-ok flag and gives a pair index of s + 32. Every other case clears pair-ok and gives a pair index of 0.
- R6: With the registered output, a request accepted on one clock edge shows up on the outputs with `out_valid` high right after that edge. When the output stage is empty, `in_ready` is high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all result fields hold their values.
- R8: During and right after reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_spec | input | 6 | Architectural register specifier |
| in_mode | input | 2 | Privilege mode: 0 user, 1..3 other modes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_idx | output | 9 | Logical register index |
| out_illegal | output | 1 | Specifier not reachable in this mode |
| out_pair_ok | output | 1 | Pair partner exists |
| out_pair_idx | output | 9 | Logical index of the 128-bit partner |

## Verification
On every cycle, the assertions check how the result fields relate to one another: an illegal result carries index 0 and no pair, a legal index stays below 160, and a pair partner sits exactly 32 above a low user register. They also check that a stalled result is held and that an accepted request appears one cycle later. Only the bench scenarios can show that each specifier in each mode reaches the right bank offset. The bench covers this with a full sweep of all 256 mode/specifier combinations and with random traffic under random back-pressure, comparing every result against a reference in order.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  localparam int SPEC_W    = 6;
  localparam int MODE_W    = 2;
  localparam int BANK_SZ   = 32;
  localparam int USER_REGS = 2 * BANK_SZ;
  localparam int NUM_MODES = 1 << MODE_W;
  localparam int TOTAL_LOG = USER_REGS + (NUM_MODES - 1) * BANK_SZ;
  localparam int PHYS_REGS = 512;
  localparam int LIDX_W    = $clog2(PHYS_REGS);

  typedef struct packed {
    logic [LIDX_W-1:0] idx;
    logic              illegal;
    logic              pair_ok;
    logic [LIDX_W-1:0] pair_idx;
  } map_res_t;
endpackage

// File: rtl/rmap_decode.sv
module rmap_decode
  import rmap_pkg::*;
(
  input  logic [SPEC_W-1:0] spec,
  input  logic [MODE_W-1:0] mode,
  output logic [LIDX_W-1:0] idx,
  output logic              illegal
);
  localparam int LOW_W = $clog2(BANK_SZ);

  logic              user_mode;
  logic              high_half;
  logic [LIDX_W-1:0] bank_base;

  assign user_mode = (mode == '0);
  assign high_half = spec[SPEC_W-1];
  // Non-user bank base: one user block of 64 plus (mode-1) private banks.
  assign bank_base = LIDX_W'(BANK_SZ) + LIDX_W'(mode) * LIDX_W'(BANK_SZ);

  always_comb begin
    illegal = 1'b0;
    if (user_mode) begin
      idx = LIDX_W'(spec);
    end else if (high_half) begin
      idx     = '0;
      illegal = 1'b1;
    end else begin
      idx = bank_base + LIDX_W'(spec[LOW_W-1:0]);
    end
  end
endmodule

// File: rtl/rmap_pair.sv
module rmap_pair
  import rmap_pkg::*;
#(
  parameter bit PAIR_EN = 1'b1
) (
  input  logic [SPEC_W-1:0] spec,
  input  logic [MODE_W-1:0] mode,
  output logic              pair_ok,
  output logic [LIDX_W-1:0] pair_idx
);
  generate
    if (PAIR_EN) begin : g_pair
      always_comb begin
        pair_ok  = (mode == '0) && !spec[SPEC_W-1];
        pair_idx = pair_ok ? LIDX_W'(spec) + LIDX_W'(BANK_SZ) : '0;
      end
    end else begin : g_nopair
      logic unused_in;
      assign unused_in = ^{spec, mode};
      assign pair_ok   = 1'b0;
      assign pair_idx  = '0;
    end
  endgenerate
endmodule

// File: rtl/rmap_stage.sv
module rmap_stage #(
  parameter bit REG_OUT = 1'b1,
  parameter int W       = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;

      assign in_ready = !vld_q || out_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) dat_q <= in_data;
        end
      end

      assign out_valid = vld_q;
      assign out_data  = dat_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign in_ready   = out_ready;
      assign out_valid  = in_valid;
      assign out_data   = in_data;
    end
  endgenerate
endmodule

// File: rtl/rmap_bank_mapper.sv
module rmap_bank_mapper
  import rmap_pkg::*;
#(
  parameter bit REG_OUT = 1'b1,
  parameter bit PAIR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SPEC_W-1:0] in_spec,
  input  logic [MODE_W-1:0] in_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LIDX_W-1:0] out_idx,
  output logic              out_illegal,
  output logic              out_pair_ok,
  output logic [LIDX_W-1:0] out_pair_idx
);
  localparam int RES_W = $bits(map_res_t);

  map_res_t res_d, res_q;

  rmap_decode u_decode (
    .spec    (in_spec),
    .mode    (in_mode),
    .idx     (res_d.idx),
    .illegal (res_d.illegal)
  );

  rmap_pair #(.PAIR_EN(PAIR_EN)) u_pair (
    .spec     (in_spec),
    .mode     (in_mode),
    .pair_ok  (res_d.pair_ok),
    .pair_idx (res_d.pair_idx)
  );

  rmap_stage #(.REG_OUT(REG_OUT), .W(RES_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_q)
  );

  assign out_idx      = res_q.idx;
  assign out_illegal  = res_q.illegal;
  assign out_pair_ok  = res_q.pair_ok;
  assign out_pair_idx = res_q.pair_idx;
endmodule

// File: rtl/rmap_checker.sv
module rmap_checker
  import rmap_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LIDX_W-1:0] out_idx,
  input logic              out_illegal,
  input logic              out_pair_ok,
  input logic [LIDX_W-1:0] out_pair_idx
);
  assert_illegal_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_idx == '0 && !out_pair_ok));

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_idx < LIDX_W'(TOTAL_LOG)));

  assert_pair_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pair_ok) |->
      (out_idx < LIDX_W'(BANK_SZ) && out_pair_idx == out_idx + LIDX_W'(BANK_SZ)));

  assert_nopair_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_pair_ok) |-> (out_pair_idx == '0));

  generate
    if (REG_OUT) begin : g_reg_props
      assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
          (out_valid && $stable(out_idx) && $stable(out_illegal) &&
           $stable(out_pair_ok) && $stable(out_pair_idx)));

      assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

      assert_empty_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

      assert_reset_R8: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
    end
  endgenerate
endmodule

bind rmap_bank_mapper rmap_checker #(.REG_OUT(REG_OUT)) u_rmap_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_idx      (out_idx),
  .out_illegal  (out_illegal),
  .out_pair_ok  (out_pair_ok),
  .out_pair_idx (out_pair_idx)
);

// File: tb/test_rmap_bank_mapper.sv
`timescale 1ns/1ps
module test_rmap_bank_mapper;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [5:0] in_spec;
  logic [1:0] in_mode;
  logic       out_valid;
  logic       out_ready;
  logic [8:0] out_idx;
  logic       out_illegal;
  logic       out_pair_ok;
  logic [8:0] out_pair_idx;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [8:0] idx;
    logic       ill;
    logic       pok;
    logic [8:0] pidx;
  } exp_t;

  exp_t exp_q[$];
  logic stall_prev = 1'b0;
  exp_t stall_val;

  always #10 clk = ~clk;

  rmap_bank_mapper i_rmap_bank_mapper (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_spec(in_spec), .in_mode(in_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_idx(out_idx), .out_illegal(out_illegal),
    .out_pair_ok(out_pair_ok), .out_pair_idx(out_pair_idx)
  );

  function automatic exp_t ref_map(input logic [1:0] m, input logic [5:0] s);
    exp_t e;
    e = '0;
    if (m == 2'd0) begin
      e.idx = {3'b0, s};
      if (!s[5]) begin
        e.pok  = 1'b1;
        e.pidx = {3'b0, s} + 9'd32;
      end
    end else if (s[5]) begin
      e.ill = 1'b1;
    end else begin
      e.idx = 9'd32 + 9'd32 * {7'b0, m} + {4'b0, s[4:0]};
    end
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic string tag_of(input exp_t e);
    if (e.ill) return "R3";
    if (e.idx < 9'd64) return "R1";
    return "R2";
  endfunction

  // Drive after the falling edge, then sample just before the rising edge.
  task automatic step(input bit v, input logic [1:0] m, input logic [5:0] s, input bit rdy);
    exp_t got;
    exp_t e;
    @(negedge clk);
    #1;
    in_valid  = v;
    in_mode   = m;
    in_spec   = s;
    out_ready = rdy;
    #8;
    got = '{out_idx, out_illegal, out_pair_ok, out_pair_idx};
    if (stall_prev) begin
      chk(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
      chk(got == stall_val, "R7 fields held", int'(got), int'(stall_val));
    end
    stall_prev = out_valid && !out_ready;
    stall_val  = got;
    if (in_valid && in_ready) exp_q.push_back(ref_map(m, s));
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected output", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk(got.idx == e.idx && got.ill == e.ill, tag_of(e), int'(got.idx), int'(e.idx));
        chk(got.pok == e.pok && got.pidx == e.pidx, "R5 pair", int'(got.pidx), int'(e.pidx));
        if (!got.ill) chk(got.idx < 9'd160, "R4 range", int'(got.idx), 159);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; in_valid = 1'b0; in_mode = '0; in_spec = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #9;
    chk(out_valid == 1'b0, "R8 reset valid", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #9;
    chk(out_valid == 1'b0, "R8 after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R6 empty ready", int'(in_ready), 1);

    // R6: single request, visible one cycle later.
    step(1'b1, 2'd2, 6'd5, 1'b1);
    step(1'b0, 2'd0, 6'd0, 1'b1);
    chk(out_valid == 1'b1 && out_idx == 9'd101, "R6 latency", int'(out_idx), 101);
    step(1'b0, 2'd0, 6'd0, 1'b1);

    // Directed corners: R1 top, R2 bank edges, R3 illegal, R5 pair 1->33.
    step(1'b1, 2'd0, 6'd63, 1'b1);
    step(1'b1, 2'd0, 6'd1, 1'b1);
    step(1'b1, 2'd1, 6'd0, 1'b1);
    step(1'b1, 2'd3, 6'd31, 1'b1);
    step(1'b1, 2'd3, 6'd32, 1'b1);
    step(1'b0, 2'd0, 6'd0, 1'b1);
    chk(out_illegal == 1'b1 && out_idx == 9'd0, "R3 forced zero", int'(out_idx), 0);
    step(1'b0, 2'd0, 6'd0, 1'b1);

    // R7: stall with a result held, then release.
    step(1'b1, 2'd1, 6'd7, 1'b1);
    repeat (4) step(1'b1, 2'd2, 6'd9, 1'b0);
    step(1'b0, 2'd0, 6'd0, 1'b1);
    step(1'b0, 2'd0, 6'd0, 1'b1);

    // Full sweep of every mode and specifier (R1, R2, R3, R5).
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 64; s++)
        step(1'b1, 2'(m), 6'(s), 1'b1);

    // Random traffic with back-pressure.
    for (int k = 0; k < 3000; k++)
      step(($urandom % 4) != 0, 2'($urandom), 6'($urandom), ($urandom % 3) != 0);

    repeat (4) step(1'b0, 2'd0, 6'd0, 1'b1);
    chk(exp_q.size() == 0, "R6 drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule